// File: doc/BRIEF.md
# Scaled Radix-2 Decimation-in-Frequency Butterfly

This block is the arithmetic core of a 1024-point in-place FFT built on the decimation-in-frequency scheme. Each accepted beat carries two complex operands A and B and one complex twiddle W. Two cycles later the block returns a sum result and a rotated-difference result. A per-stage halving is built into the arithmetic, so ten passes through the block cannot overflow the data word. After all ten stages the spectrum comes out at 1/1024 of the unscaled transform.

The halving on the product side costs no logic. The twiddle table already stores W/2, so the block only has to halve the sum side, and it does this with a one-bit arithmetic shift. The block also contains a small combinational helper that turns a butterfly's upper address and its stage number into an index into a 512-entry twiddle table. The table itself, the data memory and the sequencing are outside this block.

Top module: `dif_bfly_top`

## Requirements
- R1: While rst_n is low, and at the first clock edge after it is released, out_valid is 0 and all four result outputs are 0.
- R2: The sum result is floor((A+B)/2), taken separately for the real and imaginary parts of the 24-bit two's-complement operands. The floor means rounding toward negative infinity.
- R3: The product result is (A−B)·W. The twiddle parts are 21-bit two's complement with 20 fraction bits and already carry the halving. The real part is dr·wr − di·wi and the imaginary part is dr·wi + di·wr. Each is rounded half-up by adding 2^19 and then arithmetically shifting right by 20.
- R4: out_valid equals in_valid from two clock edges earlier. Beats may arrive on every cycle, with no bubbles.
- R5: While out_valid is low, the four result outputs hold their last values. Operand and twiddle inputs presented with in_valid low have no effect on any result.
- R6: A rounded product part above 2^23−1 is clamped to 2^23−1, and one below −2^23 is clamped to −2^23.
- R7: For a stage from 1 to 10 and a 10-bit upper address k, tw_index equals (k·2^(stage−1)) mod 512. This is combinational.
- R8: For a stage value of 0 or above 10, tw_index is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously, released in step with clk |
| in_valid | input | 1 | Operand beat present |
| a_re | input | 24 | Operand A, real part |
| a_im | input | 24 | Operand A, imaginary part |
| b_re | input | 24 | Operand B, real part |
| b_im | input | 24 | Operand B, imaginary part |
| tw_re | input | 21 | Pre-halved twiddle, real part, Q1.20 |
| tw_im | input | 21 | Pre-halved twiddle, imaginary part, Q1.20 |
| k_addr | input | 10 | Upper address of the butterfly, used for twiddle index |
| stage | input | 4 | Stage number 1..10 |
| out_valid | output | 1 | Result beat present |
| sum_re | output | 24 | Halved sum, real part |
| sum_im | output | 24 | Halved sum, imaginary part |
| prod_re | output | 24 | Rotated difference, real part |
| prod_im | output | 24 | Rotated difference, imaginary part |
| tw_index | output | 9 | Twiddle table index |

## Verification
The bench builds the block with its default widths: 24-bit data, a 21-bit twiddle with 20 fraction bits, and ten stages. At these widths the extreme operands can be reached directly. A full-scale negative B against a full-scale positive A, rotated by a near-unity twiddle, forces both saturation clamps. A difference of ±1 against a twiddle of exactly 2^19 lands on the rounding tie. With ten stages, the four-bit stage input can also be driven to 0 and to 11..15, which exercises the out-of-range index rule. Back-to-back beats, beats with gaps, and beats with in_valid low are all compared each cycle against a bit-exact integer model.

// File: rtl/dif_bfly_pkg.sv
package dif_bfly_pkg;
  localparam int DEF_DATA_W  = 24;
  localparam int DEF_TW_W    = 21;
  localparam int DEF_TW_FRAC = 20;
  localparam int DEF_LOG2N   = 10;
  localparam int DEF_STAGE_W = 4;

  // Saturate a wide signed value into a narrower signed width
  function automatic logic [63:0] sat_to(input logic signed [63:0] v, input int w);
    logic signed [63:0] hi;
    logic signed [63:0] lo;
    hi = (64'sd1 <<< (w - 1)) - 64'sd1;
    lo = -(64'sd1 <<< (w - 1));
    if (v > hi)      sat_to = hi;
    else if (v < lo) sat_to = lo;
    else             sat_to = v;
  endfunction
endpackage

// File: rtl/dif_tw_index.sv
module dif_tw_index #(
  parameter int LOG2N   = dif_bfly_pkg::DEF_LOG2N,
  parameter int STAGE_W = dif_bfly_pkg::DEF_STAGE_W
) (
  input  logic [LOG2N-1:0]   k_addr,
  input  logic [STAGE_W-1:0] stage,
  output logic [LOG2N-2:0]   tw_index
);
  localparam int AW = LOG2N - 1;

  logic [AW-1:0] cand [LOG2N+1];

  assign cand[0] = '0;

  // One shifted candidate per legal stage value
  for (genvar g = 1; g <= LOG2N; g++) begin : g_stage
    logic [LOG2N-1:0] shifted;
    assign shifted = k_addr << (g - 1);
    assign cand[g] = shifted[AW-1:0];
  end

  always_comb begin
    tw_index = '0;
    for (int s = 1; s <= LOG2N; s++) begin
      if (stage == STAGE_W'(s)) tw_index = cand[s];
    end
  end
endmodule

// File: rtl/dif_sum_half.sv
module dif_sum_half #(
  parameter int DATA_W = dif_bfly_pkg::DEF_DATA_W
) (
  input  logic signed [DATA_W-1:0] x,
  input  logic signed [DATA_W-1:0] y,
  output logic signed [DATA_W-1:0] half
);
  logic signed [DATA_W:0] full;

  // Dropping the LSB of the widened sum is a floor divide by two
  assign full = (DATA_W+1)'(x) + (DATA_W+1)'(y);
  assign half = full[DATA_W:1];
endmodule

// File: rtl/dif_cmul_round.sv
module dif_cmul_round #(
  parameter int DATA_W  = dif_bfly_pkg::DEF_DATA_W,
  parameter int TW_W    = dif_bfly_pkg::DEF_TW_W,
  parameter int TW_FRAC = dif_bfly_pkg::DEF_TW_FRAC
) (
  input  logic signed [DATA_W:0]   dr,
  input  logic signed [DATA_W:0]   di,
  input  logic signed [TW_W-1:0]   wr,
  input  logic signed [TW_W-1:0]   wi,
  output logic signed [DATA_W-1:0] pr,
  output logic signed [DATA_W-1:0] pi
);
  localparam int PW = DATA_W + 1 + TW_W;
  localparam int AW = PW + 2;

  logic signed [PW-1:0] m_rr, m_ii, m_ri, m_ir;
  logic signed [AW-1:0] acc [2];
  logic signed [AW-1:0] rnd_c;
  logic [DATA_W-1:0]    res [2];

  assign m_rr = PW'(dr) * PW'(wr);
  assign m_ii = PW'(di) * PW'(wi);
  assign m_ri = PW'(dr) * PW'(wi);
  assign m_ir = PW'(di) * PW'(wr);

  always_comb begin
    rnd_c = '0;
    rnd_c[TW_FRAC-1] = 1'b1;
  end

  assign acc[0] = AW'(m_rr) - AW'(m_ii);
  assign acc[1] = AW'(m_ri) + AW'(m_ir);

  for (genvar l = 0; l < 2; l++) begin : g_lane
    logic signed [AW-1:0] rounded;
    logic [63:0]          clamped;
    assign rounded = (acc[l] + rnd_c) >>> TW_FRAC;
    assign clamped = dif_bfly_pkg::sat_to(64'(rounded), DATA_W);
    assign res[l]  = clamped[DATA_W-1:0];
  end

  assign pr = res[0];
  assign pi = res[1];
endmodule

// File: rtl/dif_bfly_top.sv
module dif_bfly_top #(
  parameter int DATA_W  = dif_bfly_pkg::DEF_DATA_W,
  parameter int TW_W    = dif_bfly_pkg::DEF_TW_W,
  parameter int TW_FRAC = dif_bfly_pkg::DEF_TW_FRAC,
  parameter int LOG2N   = dif_bfly_pkg::DEF_LOG2N,
  parameter int STAGE_W = dif_bfly_pkg::DEF_STAGE_W
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  input  logic signed [DATA_W-1:0] a_re,
  input  logic signed [DATA_W-1:0] a_im,
  input  logic signed [DATA_W-1:0] b_re,
  input  logic signed [DATA_W-1:0] b_im,
  input  logic signed [TW_W-1:0]   tw_re,
  input  logic signed [TW_W-1:0]   tw_im,
  input  logic [LOG2N-1:0]         k_addr,
  input  logic [STAGE_W-1:0]       stage,
  output logic                     out_valid,
  output logic signed [DATA_W-1:0] sum_re,
  output logic signed [DATA_W-1:0] sum_im,
  output logic signed [DATA_W-1:0] prod_re,
  output logic signed [DATA_W-1:0] prod_im,
  output logic [LOG2N-2:0]         tw_index
);
  localparam int DW1 = DATA_W + 1;

  // ---- twiddle index helper ----
  dif_tw_index #(.LOG2N(LOG2N), .STAGE_W(STAGE_W)) u_idx (
    .k_addr  (k_addr),
    .stage   (stage),
    .tw_index(tw_index)
  );

  // ---- stage 1: halved sum and raw difference ----
  logic signed [DATA_W-1:0] hs_re, hs_im;
  logic signed [DW1-1:0]    df_re_d, df_im_d;

  dif_sum_half #(.DATA_W(DATA_W)) u_sum_re (.x(a_re), .y(b_re), .half(hs_re));
  dif_sum_half #(.DATA_W(DATA_W)) u_sum_im (.x(a_im), .y(b_im), .half(hs_im));

  always_comb begin
    df_re_d = DW1'(a_re) - DW1'(b_re);
    df_im_d = DW1'(a_im) - DW1'(b_im);
  end

  logic                     v1_q;
  logic signed [DATA_W-1:0] s1_re_q, s1_im_q;
  logic signed [DW1-1:0]    d1_re_q, d1_im_q;
  logic signed [TW_W-1:0]   w1_re_q, w1_im_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v1_q    <= 1'b0;
      s1_re_q <= '0;
      s1_im_q <= '0;
      d1_re_q <= '0;
      d1_im_q <= '0;
      w1_re_q <= '0;
      w1_im_q <= '0;
    end else begin
      v1_q <= in_valid;
      if (in_valid) begin
        s1_re_q <= hs_re;
        s1_im_q <= hs_im;
        d1_re_q <= df_re_d;
        d1_im_q <= df_im_d;
        w1_re_q <= tw_re;
        w1_im_q <= tw_im;
      end
    end
  end

  // ---- stage 2: complex rotate, round, clamp ----
  logic signed [DATA_W-1:0] pr_d, pi_d;

  dif_cmul_round #(.DATA_W(DATA_W), .TW_W(TW_W), .TW_FRAC(TW_FRAC)) u_cmul (
    .dr(d1_re_q), .di(d1_im_q),
    .wr(w1_re_q), .wi(w1_im_q),
    .pr(pr_d),    .pi(pi_d)
  );

  logic                     v2_q;
  logic signed [DATA_W-1:0] s2_re_q, s2_im_q, p2_re_q, p2_im_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v2_q    <= 1'b0;
      s2_re_q <= '0;
      s2_im_q <= '0;
      p2_re_q <= '0;
      p2_im_q <= '0;
    end else begin
      v2_q <= v1_q;
      if (v1_q) begin
        s2_re_q <= s1_re_q;
        s2_im_q <= s1_im_q;
        p2_re_q <= pr_d;
        p2_im_q <= pi_d;
      end
    end
  end

  assign out_valid = v2_q;
  assign sum_re    = s2_re_q;
  assign sum_im    = s2_im_q;
  assign prod_re   = p2_re_q;
  assign prod_im   = p2_im_q;
endmodule

// File: rtl/dif_bfly_checker.sv
module dif_bfly_checker #(
  parameter int DATA_W  = dif_bfly_pkg::DEF_DATA_W,
  parameter int TW_W    = dif_bfly_pkg::DEF_TW_W,
  parameter int LOG2N   = dif_bfly_pkg::DEF_LOG2N,
  parameter int STAGE_W = dif_bfly_pkg::DEF_STAGE_W
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     in_valid,
  input logic signed [DATA_W-1:0] a_re,
  input logic signed [DATA_W-1:0] a_im,
  input logic signed [DATA_W-1:0] b_re,
  input logic signed [DATA_W-1:0] b_im,
  input logic [STAGE_W-1:0]       stage,
  input logic                     out_valid,
  input logic signed [DATA_W-1:0] sum_re,
  input logic signed [DATA_W-1:0] sum_im,
  input logic signed [DATA_W-1:0] prod_re,
  input logic signed [DATA_W-1:0] prod_im,
  input logic [LOG2N-2:0]         tw_index
);
  logic                   vh1, vh2;
  logic signed [DATA_W:0] ex1_re, ex1_im, ex2_re, ex2_im;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vh1 <= 1'b0; vh2 <= 1'b0;
      ex1_re <= '0; ex1_im <= '0; ex2_re <= '0; ex2_im <= '0;
    end else begin
      vh1    <= in_valid;
      vh2    <= vh1;
      ex1_re <= (DATA_W+1)'(a_re) + (DATA_W+1)'(b_re);
      ex1_im <= (DATA_W+1)'(a_im) + (DATA_W+1)'(b_im);
      ex2_re <= ex1_re;
      ex2_im <= ex1_im;
    end
  end

  AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!out_valid && sum_re == 0 && sum_im == 0 && prod_re == 0 && prod_im == 0)); // R1

  AST_SUM_HALF: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (sum_re == (ex2_re >>> 1) && sum_im == (ex2_im >>> 1))); // R2

  AST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == vh2); // R4

  AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> ($stable(sum_re) && $stable(sum_im) && $stable(prod_re) && $stable(prod_im))); // R5

  AST_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (stage == 0 || stage > STAGE_W'(LOG2N)) |-> tw_index == 0); // R8
endmodule

bind dif_bfly_top dif_bfly_checker #(
  .DATA_W(DATA_W), .TW_W(TW_W), .LOG2N(LOG2N), .STAGE_W(STAGE_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
  .a_re(a_re), .a_im(a_im), .b_re(b_re), .b_im(b_im),
  .stage(stage), .out_valid(out_valid),
  .sum_re(sum_re), .sum_im(sum_im), .prod_re(prod_re), .prod_im(prod_im),
  .tw_index(tw_index)
);

// File: tb/dif_bfly_top_bench.sv
module dif_bfly_top_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n;
  logic in_valid;
  logic signed [23:0] a_re, a_im, b_re, b_im;
  logic signed [20:0] tw_re, tw_im;
  logic [9:0] k_addr;
  logic [3:0] stage;
  logic out_valid;
  logic signed [23:0] sum_re, sum_im, prod_re, prod_im;
  logic [8:0] tw_index;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dif_bfly_top u_dif_bfly_top (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .a_re(a_re), .a_im(a_im), .b_re(b_re), .b_im(b_im),
    .tw_re(tw_re), .tw_im(tw_im), .k_addr(k_addr), .stage(stage),
    .out_valid(out_valid), .sum_re(sum_re), .sum_im(sum_im),
    .prod_re(prod_re), .prod_im(prod_im), .tw_index(tw_index)
  );

  typedef struct {
    bit v;
    int sre, sim, pre, pim;
  } exp_t;

  exp_t pipe[$];
  exp_t held;

  function automatic int clamp24(longint x);
    if (x > 64'sd8388607)  return 8388607;
    if (x < -64'sd8388608) return -8388608;
    return int'(x);
  endfunction

  function automatic exp_t model(bit v, int ar, int ai, int br, int bi, int wr, int wi);
    exp_t e;
    longint dr, di, pr, pi;
    e.v   = v;
    e.sre = (ar + br) >>> 1;
    e.sim = (ai + bi) >>> 1;
    dr = longint'(ar) - longint'(br);
    di = longint'(ai) - longint'(bi);
    pr = dr * wr - di * wi;
    pi = dr * wi + di * wr;
    e.pre = clamp24((pr + 64'sd524288) >>> 20);
    e.pim = clamp24((pi + 64'sd524288) >>> 20);
    return e;
  endfunction

  function automatic int sx(int x, int w);
    int sh;
    sh = 32 - w;
    return (x <<< sh) >>> sh;
  endfunction

  task automatic check(string req, string what, int act, int expv);
    n_tests++;
    if (act != expv) begin
      n_fail++;
      $display("FAIL %s %s actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  task automatic check_outputs();
    exp_t e;
    e = pipe.pop_front();
    check("R4", "out_valid", int'(out_valid), int'(e.v));
    if (e.v) held = e;
    // R2 sum path, R3/R6 product path; when idle these confirm R5 hold
    check(e.v ? "R2" : "R5", "sum_re",  int'(sum_re),  held.sre);
    check(e.v ? "R2" : "R5", "sum_im",  int'(sum_im),  held.sim);
    check(e.v ? "R3" : "R5", "prod_re", int'(prod_re), held.pre);
    check(e.v ? "R3" : "R5", "prod_im", int'(prod_im), held.pim);
  endtask

  task automatic beat(bit v, int ar, int ai, int br, int bi, int wr, int wi, int k, int st);
    int expi;
    @(negedge clk);
    check_outputs();
    in_valid = v;
    a_re = ar[23:0]; a_im = ai[23:0]; b_re = br[23:0]; b_im = bi[23:0];
    tw_re = wr[20:0]; tw_im = wi[20:0];
    k_addr = k[9:0]; stage = st[3:0];
    pipe.push_back(model(v, ar, ai, br, bi, wr, wi));
    #1;
    expi = (st >= 1 && st <= 10) ? ((k << (st - 1)) & 511) : 0;
    check((st >= 1 && st <= 10) ? "R7" : "R8", "tw_index", int'(tw_index), expi);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0;
    a_re = '0; a_im = '0; b_re = '0; b_im = '0; tw_re = '0; tw_im = '0;
    k_addr = '0; stage = '0;
    held = '{v: 1'b0, sre: 0, sim: 0, pre: 0, pim: 0};
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", "out_valid", int'(out_valid), 0);
    check("R1", "sum_re", int'(sum_re), 0);
    check("R1", "prod_im", int'(prod_im), 0);
    rst_n = 1'b1;
    pipe.push_back(held);
    pipe.push_back(held);

    // R2 floor halving: 1+0 -> 0, -1+0 -> -1
    beat(1, 1, -1, 0, 0, 0, 0, 0, 1);
    beat(1, -3, 5, 0, 2, 0, 0, 1, 2);
    // R3 rounding tie: d=1,w=2^19 -> 1 ; d=-1 -> 0
    beat(1, 1, -1, 0, 0, 524288, 0, 3, 3);
    beat(1, 0, 0, 1, -1, 524288, 524288, 5, 10);
    // R6 saturation both ways with near-unity twiddle
    beat(1, 8388607, -8388608, -8388608, 8388607, 1048575, 0, 1023, 10);
    beat(1, -8388608, 8388607, 8388607, -8388608, 1048575, -1048576, 512, 9);
    // R5: idle beats with junk inputs must not change results
    beat(0, 12345, -999, 777, 31, 1000, -2000, 7, 0);
    beat(0, -4444, 2222, 1, 0, -77, 88, 9, 11);
    beat(0, 99, 99, 99, 99, 99, 99, 1023, 15);
    // R4: back-to-back and gapped random beats
    for (int i = 0; i < 400; i++) begin
      int ar, ai, br, bi, wr, wi;
      bit v;
      v  = ($urandom % 4) != 0;
      ar = sx(int'($urandom), 24); ai = sx(int'($urandom), 24);
      br = sx(int'($urandom), 24); bi = sx(int'($urandom), 24);
      if (i % 2 == 0) begin
        wr = sx(int'($urandom), 21); wi = sx(int'($urandom), 21);
      end else begin
        wr = sx(int'($urandom), 20); wi = sx(int'($urandom), 20);
      end
      beat(v, ar, ai, br, bi, wr, wi, int'($urandom % 1024), int'($urandom % 16));
    end
    // drain
    beat(0, 0, 0, 0, 0, 0, 0, 0, 4);
    beat(0, 0, 0, 0, 0, 0, 0, 0, 0);
    beat(0, 0, 0, 0, 0, 0, 0, 0, 0);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule